// File: doc/BRIEF.md
# TLB maintenance command decoder

This block turns a single write to a translation-buffer maintenance operation register into flush commands for every affected instruction and data translation buffer in a multi-core cluster. Each write carries a 4-bit operation code, a 32-bit data word and the index of the core that issued it. The operation code picks one of four flush kinds and a scope. The scope is either a broadcast to the instruction and data buffers of all cores, or a local command to only the issuing core's instruction buffer or only its data buffer.

The data word supplies two values. A page number comes from bits 31:12, and the buffer treats the 12 bits below it as zero. An address-space identifier comes from bits 7:0. The decoder pulses one flush strobe per targeted buffer. It holds the flush kind, page and identifier steady on shared buses. It then waits until every targeted buffer has reported done, and only then acknowledges the write. While a command is outstanding the write port reports not-ready, and any write offered during that time is ignored.

Top module: `tlb_maint_decoder`

## Requirements
- R1: While reset is low and in the first cycle after it, `wr_ready_o` is 1, `wr_ack_o` is 0, and no flush strobe is high.
- R2: `wr_op_i[3:2]` selects the kind: 0 all entries, 1 page plus identifier, 2 identifier only, 3 page across all identifiers. `flush_kind_o` carries this code. `wr_op_i[1:0]` selects the scope: 0 and 1 broadcast, 2 local instruction buffer, 3 local data buffer. Kind 3 exists only with broadcast scope.
- R3: A broadcast command pulses every bit of both `iflush_o` and `dflush_o`.
- R4: A local command pulses only bit `wr_src_i` of `iflush_o` (scope 2) or of `dflush_o` (scope 3).
- R5: `flush_page_o` equals `wr_data_i[31:12]` for kinds 1 and 3, and is 0 for kinds 0 and 2.
- R6: `flush_asid_o` equals `wr_data_i[7:0]` for kinds 1 and 2, and is 0 for kinds 0 and 3.
- R7: Strobes are high for exactly the one cycle after the clock edge that accepts the write. Kind, page and identifier are valid from that cycle and stay unchanged until the next command that pulses strobes.
- R8: `wr_ack_o` pulses in the cycle after the edge at which the last outstanding targeted done bit is seen. A done bit counts from the strobe cycle onward. Done bits for buffers that were not targeted, or done bits that arrive while idle, have no effect.
- R9: `wr_ready_o` is 0 from the strobe cycle until the ack cycle, and a write offered while it is 0 produces no strobe.
- R10: Codes 14 and 15, and a local command whose `wr_src_i` is not below the core count, pulse no strobe. They leave the fields unchanged, keep `wr_ready_o` at 1, and ack in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Maintenance register write offered |
| wr_op_i | input | 4 | Operation code (kind and scope) |
| wr_data_i | input | 32 | Write data carrying page and identifier |
| wr_src_i | input | SRC_W | Index of the issuing core |
| wr_ready_o | output | 1 | Write port can accept |
| wr_ack_o | output | 1 | Write completed by all targets |
| iflush_o | output | NUM_CORES | Per-core instruction buffer flush strobe |
| dflush_o | output | NUM_CORES | Per-core data buffer flush strobe |
| flush_kind_o | output | 2 | Flush kind code |
| flush_page_o | output | 20 | Page number |
| flush_asid_o | output | 8 | Address-space identifier |
| idone_i | input | NUM_CORES | Per-core instruction buffer flush done |
| ddone_i | input | NUM_CORES | Per-core data buffer flush done |

## Verification
The bench builds the block with NUM_CORES set to 3. At that count the source index is two bits wide, so the unused index 3 can be driven, which tests the local-command path that has no target. Three cores also keep the local target masks visibly distinct for each issuing core, and a broadcast gives six separate done bits. That makes it possible to finish a command through several separate done bits, to send done bits to buffers that were not targeted, and to hold a command open while another write is offered.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int DATA_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = DATA_W - PAGE_LSB;
  localparam int ASID_W   = 8;
  localparam int OP_W     = 4;

  typedef enum logic [1:0] {
    FK_ALL       = 2'd0,
    FK_PAGE_ASID = 2'd1,
    FK_ASID      = 2'd2,
    FK_PAGE_ANY  = 2'd3
  } flush_kind_e;

  typedef enum logic [1:0] {
    SC_BCAST_SH = 2'd0,
    SC_BCAST    = 2'd1,
    SC_LOCAL_I  = 2'd2,
    SC_LOCAL_D  = 2'd3
  } scope_e;

  typedef struct packed {
    flush_kind_e           kind;
    logic                  bcast;
    logic                  loc_i;
    logic                  loc_d;
    logic                  legal;
    logic [PAGE_W-1:0]     page;
    logic [ASID_W-1:0]     asid;
  } maint_cmd_t;
endpackage

// File: rtl/tlbm_op_decode.sv
module tlbm_op_decode
  import tlbm_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  output maint_cmd_t        cmd_o
);
  flush_kind_e kind;
  scope_e      scope;
  logic        use_page;
  logic        use_asid;
  logic        unused_bits;

  assign kind        = flush_kind_e'(op_i[3:2]);
  assign scope       = scope_e'(op_i[1:0]);
  assign unused_bits = ^data_i[PAGE_LSB-1:ASID_W];

  always_comb begin
    use_page = (kind == FK_PAGE_ASID) || (kind == FK_PAGE_ANY);
    use_asid = (kind == FK_PAGE_ASID) || (kind == FK_ASID);

    cmd_o.kind  = kind;
    cmd_o.bcast = (scope == SC_BCAST_SH) || (scope == SC_BCAST);
    cmd_o.loc_i = (scope == SC_LOCAL_I);
    cmd_o.loc_d = (scope == SC_LOCAL_D);
    // page-across-all-ids has no local form
    cmd_o.legal = !((kind == FK_PAGE_ANY) && !cmd_o.bcast);
    cmd_o.page  = use_page ? data_i[DATA_W-1:PAGE_LSB] : '0;
    cmd_o.asid  = use_asid ? data_i[ASID_W-1:0] : '0;
  end
endmodule

// File: rtl/tlbm_target_gen.sv
module tlbm_target_gen
  import tlbm_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SRC_W     = 2
) (
  input  maint_cmd_t           cmd_i,
  input  logic [SRC_W-1:0]     src_i,
  output logic [NUM_CORES-1:0] imask_o,
  output logic [NUM_CORES-1:0] dmask_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic is_src;
    assign is_src     = (src_i == SRC_W'(c));
    assign imask_o[c] = cmd_i.legal && (cmd_i.bcast || (cmd_i.loc_i && is_src));
    assign dmask_o[c] = cmd_i.legal && (cmd_i.bcast || (cmd_i.loc_d && is_src));
  end
endmodule

// File: rtl/tlbm_ack_tracker.sv
module tlbm_ack_tracker #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_CORES-1:0] imask_i,
  input  logic [NUM_CORES-1:0] dmask_i,
  input  logic [NUM_CORES-1:0] idone_i,
  input  logic [NUM_CORES-1:0] ddone_i,
  output logic                 busy_o,
  output logic                 ack_o
);
  logic [NUM_CORES-1:0] pend_i_q, pend_d_q;
  logic [NUM_CORES-1:0] pend_i_nx, pend_d_nx;
  logic                 has_target;
  logic                 all_clear;

  assign has_target = |{imask_i, dmask_i};
  assign pend_i_nx  = pend_i_q & ~idone_i;
  assign pend_d_nx  = pend_d_q & ~ddone_i;
  assign all_clear  = ~|{pend_i_nx, pend_d_nx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      ack_o    <= 1'b0;
      pend_i_q <= '0;
      pend_d_q <= '0;
    end else if (start_i) begin
      busy_o   <= has_target;
      ack_o    <= !has_target;
      pend_i_q <= imask_i;
      pend_d_q <= dmask_i;
    end else if (busy_o) begin
      pend_i_q <= pend_i_nx;
      pend_d_q <= pend_d_nx;
      busy_o   <= !all_clear;
      ack_o    <= all_clear;
    end else begin
      ack_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_maint_decoder.sv
module tlb_maint_decoder
  import tlbm_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  localparam int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [3:0]           wr_op_i,
  input  logic [31:0]          wr_data_i,
  input  logic [SRC_W-1:0]     wr_src_i,
  output logic                 wr_ready_o,
  output logic                 wr_ack_o,
  output logic [NUM_CORES-1:0] iflush_o,
  output logic [NUM_CORES-1:0] dflush_o,
  output logic [1:0]           flush_kind_o,
  output logic [19:0]          flush_page_o,
  output logic [7:0]           flush_asid_o,
  input  logic [NUM_CORES-1:0] idone_i,
  input  logic [NUM_CORES-1:0] ddone_i
);
  maint_cmd_t           cmd;
  logic [NUM_CORES-1:0] imask, dmask;
  logic                 busy;
  logic                 accept;
  logic                 issue;

  tlbm_op_decode u_dec (
    .op_i   (wr_op_i),
    .data_i (wr_data_i),
    .cmd_o  (cmd)
  );

  tlbm_target_gen #(.NUM_CORES(NUM_CORES), .SRC_W(SRC_W)) u_tgt (
    .cmd_i   (cmd),
    .src_i   (wr_src_i),
    .imask_o (imask),
    .dmask_o (dmask)
  );

  assign wr_ready_o = !busy;
  assign accept     = wr_valid_i && wr_ready_o;
  assign issue      = accept && (|{imask, dmask});

  tlbm_ack_tracker #(.NUM_CORES(NUM_CORES)) u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .imask_i (imask),
    .dmask_i (dmask),
    .idone_i (idone_i),
    .ddone_i (ddone_i),
    .busy_o  (busy),
    .ack_o   (wr_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iflush_o     <= '0;
      dflush_o     <= '0;
      flush_kind_o <= '0;
      flush_page_o <= '0;
      flush_asid_o <= '0;
    end else begin
      iflush_o <= issue ? imask : '0;
      dflush_o <= issue ? dmask : '0;
      if (issue) begin
        flush_kind_o <= cmd.kind;
        flush_page_o <= cmd.page;
        flush_asid_o <= cmd.asid;
      end
    end
  end
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_valid_i,
  input logic                 wr_ready_o,
  input logic                 wr_ack_o,
  input logic [NUM_CORES-1:0] iflush_o,
  input logic [NUM_CORES-1:0] dflush_o,
  input logic [1:0]           flush_kind_o,
  input logic [19:0]          flush_page_o,
  input logic [7:0]           flush_asid_o
);
  logic any_strobe;
  assign any_strobe = |{iflush_o, dflush_o};

  // R7
  strobe_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> $past(wr_valid_i && wr_ready_o));

  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |=> !any_strobe);

  // R9
  busy_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> !wr_ready_o);

  // R3
  strobe_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({iflush_o, dflush_o}) == 0) || ($countones({iflush_o, dflush_o}) == 1) ||
    ($countones({iflush_o, dflush_o}) == 2 * NUM_CORES));

  // R7
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ready_o && $past(!wr_ready_o)) |->
      ($stable(flush_kind_o) && $stable(flush_page_o) && $stable(flush_asid_o)));

  // R8
  ack_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> wr_ready_o);

  // R2
  page_any_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strobe && flush_kind_o == 2'd3) |-> (&iflush_o && &dflush_o));
endmodule

bind tlb_maint_decoder tlbm_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_ready_o   (wr_ready_o),
  .wr_ack_o     (wr_ack_o),
  .iflush_o     (iflush_o),
  .dflush_o     (dflush_o),
  .flush_kind_o (flush_kind_o),
  .flush_page_o (flush_page_o),
  .flush_asid_o (flush_asid_o)
);

// File: tb/tlb_maint_decoder_bench.sv
module tlb_maint_decoder_bench;
  localparam int N  = 3;
  localparam int SW = 2;
  localparam int NV = 17;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] data;
    logic [1:0]  src;
    logic [2:0]  ei;
    logic [2:0]  ed;
    logic [1:0]  kind;
    logic [19:0] page;
    logic [7:0]  asid;
    logic        legal;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd0,  32'hDEADBEEF, 2'd0, 3'b111, 3'b111, 2'd0, 20'h00000, 8'h00, 1'b1},
    '{4'd1,  32'h12345678, 2'd1, 3'b111, 3'b111, 2'd0, 20'h00000, 8'h00, 1'b1},
    '{4'd2,  32'hFFFFFFFF, 2'd2, 3'b100, 3'b000, 2'd0, 20'h00000, 8'h00, 1'b1},
    '{4'd3,  32'h0000FFFF, 2'd0, 3'b000, 3'b001, 2'd0, 20'h00000, 8'h00, 1'b1},
    '{4'd4,  32'hABCDE042, 2'd2, 3'b111, 3'b111, 2'd1, 20'hABCDE, 8'h42, 1'b1},
    '{4'd5,  32'h00001FFF, 2'd1, 3'b111, 3'b111, 2'd1, 20'h00001, 8'hFF, 1'b1},
    '{4'd6,  32'h80000001, 2'd1, 3'b010, 3'b000, 2'd1, 20'h80000, 8'h01, 1'b1},
    '{4'd7,  32'h7FFFF0AA, 2'd2, 3'b000, 3'b100, 2'd1, 20'h7FFFF, 8'hAA, 1'b1},
    '{4'd8,  32'hFFFFF05A, 2'd0, 3'b111, 3'b111, 2'd2, 20'h00000, 8'h5A, 1'b1},
    '{4'd9,  32'h000000C3, 2'd2, 3'b111, 3'b111, 2'd2, 20'h00000, 8'hC3, 1'b1},
    '{4'd10, 32'h12345601, 2'd0, 3'b001, 3'b000, 2'd2, 20'h00000, 8'h01, 1'b1},
    '{4'd11, 32'h00000080, 2'd1, 3'b000, 3'b010, 2'd2, 20'h00000, 8'h80, 1'b1},
    '{4'd12, 32'h12345FFF, 2'd1, 3'b111, 3'b111, 2'd3, 20'h12345, 8'h00, 1'b1},
    '{4'd13, 32'hFFFFFFFF, 2'd0, 3'b111, 3'b111, 2'd3, 20'hFFFFF, 8'h00, 1'b1},
    '{4'd14, 32'h55555555, 2'd0, 3'b000, 3'b000, 2'd3, 20'hFFFFF, 8'h00, 1'b0},
    '{4'd15, 32'hAAAAAAAA, 2'd2, 3'b000, 3'b000, 2'd3, 20'hFFFFF, 8'h00, 1'b0},
    '{4'd2,  32'h00003003, 2'd3, 3'b000, 3'b000, 2'd3, 20'hFFFFF, 8'h00, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [3:0]    wr_op = '0;
  logic [31:0]   wr_data = '0;
  logic [SW-1:0] wr_src = '0;
  logic          wr_ready, wr_ack;
  logic [N-1:0]  iflush, dflush;
  logic [1:0]    kind;
  logic [19:0]   page;
  logic [7:0]    asid;
  logic [N-1:0]  idone = '0;
  logic [N-1:0]  ddone = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tlb_maint_decoder #(.NUM_CORES(N)) u_tlb_maint_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_valid_i   (wr_valid),
    .wr_op_i      (wr_op),
    .wr_data_i    (wr_data),
    .wr_src_i     (wr_src),
    .wr_ready_o   (wr_ready),
    .wr_ack_o     (wr_ack),
    .iflush_o     (iflush),
    .dflush_o     (dflush),
    .flush_kind_o (kind),
    .flush_page_o (page),
    .flush_asid_o (asid),
    .idone_i      (idone),
    .ddone_i      (ddone)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a negedge, accept on the next posedge, return at the strobe-cycle negedge
  task automatic issue(logic [3:0] op, logic [31:0] data, logic [SW-1:0] src);
    @(negedge clk);
    wr_valid = 1'b1; wr_op = op; wr_data = data; wr_src = src;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #15;
    check("R1 ready in reset", wr_ready, 1);
    check("R1 ack in reset", wr_ack, 0);
    check("R1 strobes in reset", {iflush, dflush}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", wr_ready, 1);
    check("R1 strobes after reset", {iflush, dflush}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].data, VEC[v].src);
      check("R3/R4 iflush", iflush, VEC[v].ei);
      check("R3/R4 dflush", dflush, VEC[v].ed);
      check("R2 kind", kind, VEC[v].kind);
      check("R5 page", page, VEC[v].page);
      check("R6 asid", asid, VEC[v].asid);
      if (VEC[v].legal) begin
        check("R9 ready low in strobe cycle", wr_ready, 0);
        check("R8 no early ack", wr_ack, 0);
        @(negedge clk);
        check("R7 strobe single pulse", {iflush, dflush}, 0);
        idone = VEC[v].ei; ddone = VEC[v].ed;
        @(negedge clk);
        idone = '0; ddone = '0;
        check("R8 ack after last done", wr_ack, 1);
        check("R9 ready at ack", wr_ready, 1);
      end else begin
        check("R10 immediate ack", wr_ack, 1);
        check("R10 ready stays high", wr_ready, 1);
      end
      @(negedge clk);
      check("R8 ack single pulse", wr_ack, 0);
    end

    // R8: done in the strobe cycle counts
    issue(4'd1, 32'h0, 2'd0);
    idone = 3'b111; ddone = 3'b111;
    @(negedge clk);
    idone = '0; ddone = '0;
    check("R8 done in strobe cycle", wr_ack, 1);
    @(negedge clk);

    // R9: partial completion holds off ack; writes offered while busy are ignored
    issue(4'd0, 32'h0, 2'd0);
    idone = 3'b111;
    @(negedge clk);
    idone = '0;
    wr_valid = 1'b1; wr_op = 4'd6; wr_src = 2'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 no strobe while busy", {iflush, dflush}, 0);
      check("R9 ready low while busy", wr_ready, 0);
      check("R8 no ack with data pending", wr_ack, 0);
    end
    wr_valid = 1'b0;
    ddone = 3'b111;
    @(negedge clk);
    ddone = '0;
    check("R8 ack after split done", wr_ack, 1);
    @(negedge clk);
    check("R9 offered write was dropped", {iflush, dflush}, 0);

    // R8: done from buffers that were not targeted is ignored
    issue(4'd6, 32'h00005000, 2'd1);
    check("R4 local inst core1", iflush, 3'b010);
    idone = 3'b101; ddone = 3'b111;
    @(negedge clk);
    check("R8 foreign done ignored", wr_ack, 0);
    @(negedge clk);
    check("R8 foreign done ignored again", wr_ack, 0);
    idone = 3'b010; ddone = '0;
    @(negedge clk);
    idone = '0;
    check("R8 ack after targeted done", wr_ack, 1);

    // R8: done while idle does not pre-clear a later command
    idone = 3'b111; ddone = 3'b111;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle done no ack", wr_ack, 0);
    idone = '0; ddone = '0;
    issue(4'd3, 32'h0, 2'd2);
    check("R4 local data core2", dflush, 3'b100);
    @(negedge clk);
    check("R8 idle done not counted", wr_ack, 0);
    ddone = 3'b100;
    @(negedge clk);
    ddone = '0;
    check("R8 ack local data", wr_ack, 1);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule